// File: doc/BRIEF.md
# E1 Timeslot-0 E-bit and Remote Alarm Generator

This block decides the E-bit values and the remote alarm indication (RAI) bit that an E1 transmitter places in timeslot 0. The receive framer reports the outcome of each CRC-4 submultiframe check as a one-cycle strobe, together with a submultiframe index and an error flag. Each result is kept in a small store. At the start of the next transmit multiframe the stored results are frozen into the outgoing E-bits, so the far end learns which of its submultiframes arrived damaged.

Three sources can supply the E-bits. The first is the stored reports, used when automatic insertion is on. The second is a fixed polarity, used when automatic insertion is on and the receiver has lost CRC-4 multiframe alignment. The third is a software-supplied value, used when automatic insertion is off. The RAI bit is the OR of a software request and, when automatic alarm is enabled, the receiver's loss-of-frame-alignment flag. It clears by itself once alignment returns.

Top module: `e1_ebit_rai_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ebit_out` is all ones and `rai_out` is 0. Stored results reset to error-free (1), so the first multiframe start with automatic insertion on, and not in async, gives all ones.
- R2: A strobe on `crc_valid` with index `crc_smf` = i stores the result for E-bit i. A set `crc_err` stores 0 (errored) and a clear one stores 1 (error-free). Bit i of `ebit_out` carries submultiframe i, so bit 0 is the first submultiframe.
- R3: `ebit_out` changes only in the cycle after a cycle with `tx_mf_start` high. Otherwise it holds, whatever the other inputs do.
- R4: With `auto_ebit_en` = 1 and `mf_async` = 0, a multiframe start loads the stored results into `ebit_out`, visible one cycle later.
- R5: With `auto_ebit_en` = 1 and `mf_async` = 1, a multiframe start sets every E-bit to `async_ebit_pol`, regardless of the stored results.
- R6: With `auto_ebit_en` = 0, a multiframe start copies `sw_ebit` into `ebit_out`, and `mf_async` has no effect.
- R7: A strobe in the same cycle as `tx_mf_start` is not part of that multiframe's E-bits. It appears at the following multiframe start.
- R8: With `auto_rai_en` = 1, `rai_out` goes to 1 one cycle after `lfa` is high and returns to 0 one cycle after `lfa` clears, unless software requests RAI.
- R9: With `auto_rai_en` = 0, `lfa` has no effect on `rai_out`.
- R10: `sw_rai` = 1 drives `rai_out` to 1 one cycle later, independent of the automatic alarm. `rai_out` is 0 one cycle after neither source is active.
- R11: A stored result persists until a later strobe for the same index overwrites it, so it is repeated at every following multiframe start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_valid | input | 1 | One-cycle strobe: a submultiframe check result is present |
| crc_smf | input | IDX_W (1) | Submultiframe index of the result |
| crc_err | input | 1 | 1 = CRC-4 mismatch in that submultiframe |
| lfa | input | 1 | Receiver has lost basic frame alignment |
| mf_async | input | 1 | Receiver is out of CRC-4 multiframe alignment |
| tx_mf_start | input | 1 | One-cycle pulse at the start of a transmit multiframe |
| auto_ebit_en | input | 1 | Take E-bits from received check results |
| async_ebit_pol | input | 1 | E-bit value sent during async state |
| auto_rai_en | input | 1 | Raise RAI automatically on loss of alignment |
| sw_rai | input | 1 | Software RAI request |
| sw_ebit | input | N_SMF (2) | Software E-bits used when automatic insertion is off |
| ebit_out | output | N_SMF (2) | E-bits for the current transmit multiframe |
| rai_out | output | 1 | RAI bit for transmit timeslot 0 |

## Verification
A wrong entry in the result store cannot be seen until the next multiframe start. It then appears on one specific bit of `ebit_out` one cycle later and stays there for the whole multiframe. For that reason each store pattern is followed by a multiframe pulse and a check of both bits. A bad source selection shows up as E-bits that ignore the async flag or the software value, again only after a multiframe start. RAI faults appear within one cycle of a change on `lfa`, `sw_rai` or `auto_rai_en`.

// File: rtl/e1_ebit_pkg.sv
package e1_ebit_pkg;

  // Which source feeds the E-bits at a multiframe start
  typedef enum logic [1:0] {
    EBIT_SRC_STORED = 2'd0,
    EBIT_SRC_ASYNC  = 2'd1,
    EBIT_SRC_SW     = 2'd2
  } ebit_src_e;

  function automatic ebit_src_e pick_src(input logic auto_en, input logic async_st);
    if (!auto_en)     return EBIT_SRC_SW;
    else if (async_st) return EBIT_SRC_ASYNC;
    else              return EBIT_SRC_STORED;
  endfunction

endpackage

// File: rtl/e1_smf_store.sv
module e1_smf_store #(
  parameter int N_SMF = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_err,
  output logic [N_SMF-1:0] ok_vec
);

  // One flag per submultiframe: 1 = last check clean, 0 = errored
  for (genvar i = 0; i < N_SMF; i++) begin : g_slot
    logic ok_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        ok_q <= 1'b1;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        ok_q <= ~wr_err;
      end
    end
    assign ok_vec[i] = ok_q;
  end

endmodule

// File: rtl/e1_ebit_latch.sv
module e1_ebit_latch
  import e1_ebit_pkg::*;
#(
  parameter int N_SMF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             auto_en,
  input  logic             async_st,
  input  logic             async_pol,
  input  logic [N_SMF-1:0] stored,
  input  logic [N_SMF-1:0] sw_val,
  output logic [N_SMF-1:0] ebit_q
);

  ebit_src_e        src;
  logic [N_SMF-1:0] next_val;

  always_comb begin
    src = pick_src(auto_en, async_st);
    unique case (src)
      EBIT_SRC_STORED: next_val = stored;
      EBIT_SRC_ASYNC:  next_val = {N_SMF{async_pol}};
      EBIT_SRC_SW:     next_val = sw_val;
      default:         next_val = '1;
    endcase
  end

  // Frozen for the whole multiframe
  always_ff @(posedge clk) begin
    if (rst) begin
      ebit_q <= '1;
    end else if (load) begin
      ebit_q <= next_val;
    end
  end

endmodule

// File: rtl/e1_rai_gen.sv
module e1_rai_gen (
  input  logic clk,
  input  logic rst,
  input  logic lfa,
  input  logic auto_en,
  input  logic sw_req,
  output logic rai_q
);

  logic auto_alarm;
  assign auto_alarm = auto_en & lfa;

  always_ff @(posedge clk) begin
    if (rst) begin
      rai_q <= 1'b0;
    end else begin
      rai_q <= sw_req | auto_alarm;
    end
  end

endmodule

// File: rtl/e1_ebit_rai_gen.sv
module e1_ebit_rai_gen #(
  parameter int N_SMF = 2,
  parameter int IDX_W = (N_SMF > 1) ? $clog2(N_SMF) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crc_valid,
  input  logic [IDX_W-1:0] crc_smf,
  input  logic             crc_err,
  input  logic             lfa,
  input  logic             mf_async,
  input  logic             tx_mf_start,
  input  logic             auto_ebit_en,
  input  logic             async_ebit_pol,
  input  logic             auto_rai_en,
  input  logic             sw_rai,
  input  logic [N_SMF-1:0] sw_ebit,
  output logic [N_SMF-1:0] ebit_out,
  output logic             rai_out
);

  logic [N_SMF-1:0] smf_ok;

  e1_smf_store #(.N_SMF(N_SMF), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (crc_valid),
    .wr_idx (crc_smf),
    .wr_err (crc_err),
    .ok_vec (smf_ok)
  );

  e1_ebit_latch #(.N_SMF(N_SMF)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .load      (tx_mf_start),
    .auto_en   (auto_ebit_en),
    .async_st  (mf_async),
    .async_pol (async_ebit_pol),
    .stored    (smf_ok),
    .sw_val    (sw_ebit),
    .ebit_q    (ebit_out)
  );

  e1_rai_gen u_rai (
    .clk     (clk),
    .rst     (rst),
    .lfa     (lfa),
    .auto_en (auto_rai_en),
    .sw_req  (sw_rai),
    .rai_q   (rai_out)
  );

endmodule

// File: rtl/e1_ebit_rai_gen_chk.sv
module e1_ebit_rai_gen_chk #(
  parameter int N_SMF = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_mf_start,
  input logic             auto_ebit_en,
  input logic             mf_async,
  input logic             async_ebit_pol,
  input logic             auto_rai_en,
  input logic             lfa,
  input logic             sw_rai,
  input logic [N_SMF-1:0] sw_ebit,
  input logic [N_SMF-1:0] ebit_out,
  input logic             rai_out
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ebit_out == '1) && !rai_out);

  a_r3_hold_between_starts: assert property (@(posedge clk) disable iff (rst)
    !tx_mf_start |=> $stable(ebit_out));

  a_r5_async_polarity: assert property (@(posedge clk) disable iff (rst)
    (tx_mf_start && auto_ebit_en && mf_async) |=> (ebit_out == {N_SMF{$past(async_ebit_pol)}}));

  a_r6_software_ebits: assert property (@(posedge clk) disable iff (rst)
    (tx_mf_start && !auto_ebit_en) |=> (ebit_out == $past(sw_ebit)));

  a_r8_auto_alarm_raise: assert property (@(posedge clk) disable iff (rst)
    (auto_rai_en && lfa) |=> rai_out);

  a_r10_sw_alarm: assert property (@(posedge clk) disable iff (rst)
    sw_rai |=> rai_out);

  a_r10_alarm_clear: assert property (@(posedge clk) disable iff (rst)
    (!sw_rai && !(auto_rai_en && lfa)) |=> !rai_out);

endmodule

bind e1_ebit_rai_gen e1_ebit_rai_gen_chk #(.N_SMF(N_SMF)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .tx_mf_start    (tx_mf_start),
  .auto_ebit_en   (auto_ebit_en),
  .mf_async       (mf_async),
  .async_ebit_pol (async_ebit_pol),
  .auto_rai_en    (auto_rai_en),
  .lfa            (lfa),
  .sw_rai         (sw_rai),
  .sw_ebit        (sw_ebit),
  .ebit_out       (ebit_out),
  .rai_out        (rai_out)
);

// File: tb/e1_ebit_rai_gen_bench.sv
`timescale 1ns/1ps
module e1_ebit_rai_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       crc_valid = 1'b0;
  logic [0:0] crc_smf = '0;
  logic       crc_err = 1'b0;
  logic       lfa = 1'b0;
  logic       mf_async = 1'b0;
  logic       tx_mf_start = 1'b0;
  logic       auto_ebit_en = 1'b0;
  logic       async_ebit_pol = 1'b0;
  logic       auto_rai_en = 1'b0;
  logic       sw_rai = 1'b0;
  logic [1:0] sw_ebit = 2'b00;
  logic [1:0] ebit_out;
  logic       rai_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  e1_ebit_rai_gen u_e1_ebit_rai_gen (
    .clk(clk), .rst(rst), .crc_valid(crc_valid), .crc_smf(crc_smf),
    .crc_err(crc_err), .lfa(lfa), .mf_async(mf_async),
    .tx_mf_start(tx_mf_start), .auto_ebit_en(auto_ebit_en),
    .async_ebit_pol(async_ebit_pol), .auto_rai_en(auto_rai_en),
    .sw_rai(sw_rai), .sw_ebit(sw_ebit), .ebit_out(ebit_out),
    .rai_out(rai_out)
  );

  // advance one edge; inputs are driven and outputs sampled 2 ns after it
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic strobe(input logic idx, input logic err);
    crc_valid = 1'b1; crc_smf = idx; crc_err = err;
    step();
    crc_valid = 1'b0;
  endtask

  task automatic mf_pulse();
    tx_mf_start = 1'b1;
    step();
    tx_mf_start = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    check("R1 ebit in reset", ebit_out, 2'b11);
    check("R1 rai in reset", {1'b0, rai_out}, 2'b00);
    rst = 1'b0;
    step();
    check("R1 ebit after reset", ebit_out, 2'b11);
    auto_ebit_en = 1'b1;
    mf_pulse();
    check("R1 stored results start error-free", ebit_out, 2'b11);
  endtask

  task automatic t_auto_report();
    strobe(1'b0, 1'b1);
    strobe(1'b1, 1'b0);
    check("R3 no change before multiframe start", ebit_out, 2'b11);
    mf_pulse();
    check("R2 R4 smf0 errored smf1 clean", ebit_out, 2'b10);
    strobe(1'b0, 1'b0);
    strobe(1'b1, 1'b1);
    check("R3 held while store changes", ebit_out, 2'b10);
    mf_pulse();
    check("R2 R4 smf0 clean smf1 errored", ebit_out, 2'b01);
  endtask

  task automatic t_persist();
    mf_pulse();
    check("R11 results repeated without new strobes", ebit_out, 2'b01);
  endtask

  task automatic t_coincide();
    crc_valid = 1'b1; crc_smf = 1'b0; crc_err = 1'b1;
    tx_mf_start = 1'b1;
    step();
    crc_valid = 1'b0; tx_mf_start = 1'b0;
    check("R7 coincident strobe not in this multiframe", ebit_out, 2'b01);
    mf_pulse();
    check("R7 coincident strobe in following multiframe", ebit_out, 2'b00);
  endtask

  task automatic t_async();
    mf_async = 1'b1; async_ebit_pol = 1'b1;
    step();
    check("R3 async flag alone changes nothing", ebit_out, 2'b00);
    mf_pulse();
    check("R5 async polarity one", ebit_out, 2'b11);
    async_ebit_pol = 1'b0;
    mf_pulse();
    check("R5 async polarity zero", ebit_out, 2'b00);
    mf_async = 1'b0;
    strobe(1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    mf_pulse();
    check("R4 stored results back after async", ebit_out, 2'b11);
  endtask

  task automatic t_software();
    auto_ebit_en = 1'b0; mf_async = 1'b1; async_ebit_pol = 1'b1;
    sw_ebit = 2'b10;
    mf_pulse();
    check("R6 software E-bits, async ignored", ebit_out, 2'b10);
    sw_ebit = 2'b01;
    step();
    check("R3 software value waits for start", ebit_out, 2'b10);
    mf_pulse();
    check("R6 software E-bits updated", ebit_out, 2'b01);
    mf_async = 1'b0;
  endtask

  task automatic t_rai();
    auto_rai_en = 1'b1; lfa = 1'b1;
    step();
    check("R8 auto RAI raised", {1'b0, rai_out}, 2'b01);
    lfa = 1'b0;
    step();
    check("R8 auto RAI removed", {1'b0, rai_out}, 2'b00);
    auto_rai_en = 1'b0; lfa = 1'b1;
    step(); step();
    check("R9 lfa ignored when auto off", {1'b0, rai_out}, 2'b00);
    sw_rai = 1'b1;
    step();
    check("R10 software RAI", {1'b0, rai_out}, 2'b01);
    auto_rai_en = 1'b1;
    step();
    lfa = 1'b0;
    step();
    check("R10 software RAI held after lfa clears", {1'b0, rai_out}, 2'b01);
    sw_rai = 1'b0;
    step();
    check("R10 RAI clear with no source", {1'b0, rai_out}, 2'b00);
    auto_rai_en = 1'b0;
  endtask

  initial begin
    #2;
    t_reset();
    t_auto_report();
    t_persist();
    t_coincide();
    t_async();
    t_software();
    t_rai();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule